// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block loads a configuration image into a target FPGA over the target's slave SPI port. A single start pulse runs the whole sequence. The block first pulls the target's active-low reset and the chip select low together, holds them for a minimum time, and then releases reset. It checks that the target's done flag is low. It then waits for the target's housekeeping time with chip select still low, and raises chip select.

Chip select then drops again. Image bytes arrive on a valid/ready byte port and are shifted out MSB first in SPI mode 0. After the byte flagged as last, the block checks that the done flag has gone high. It then clocks out zero bytes to start the loaded design.

Every delay is a count of system clock cycles, derived from the clock-frequency parameter. The serial clock half-period is a divider value given at start, measured in system cycles. Status is reported on four outputs: a busy flag, a success flag, a two-bit error code, and a status bit that follows the done input directly.

Top module: `cfg_loader`

## Requirements
- R1: While reset is applied and after it is released, `creset_no` and `cs_no` are 1, `sck_o` is 0, `busy_o` and `done_ok_o` are 0, and `err_o` is 0.
- R2: An accepted start drives `creset_no` and `cs_no` low in the same cycle. `creset_no` stays low for at least ceil(CLK_HZ·RST_NS/1e9) cycles (50 with a 50 MHz clock and 1000 ns), and `cs_no` stays low for that whole time.
- R3: If `cdone_i` reads 1 after reset is released, the sequence stops with `err_o` = 1 (reset failure). No serial clock pulse is issued.
- R4: After reset is released, `cs_no` stays low for at least ceil(CLK_HZ·HK_US/1e6) cycles. It then goes high for at least one cycle before the first serial clock rises.
- R5: An image byte is taken when `byte_valid_i` and `byte_ready_o` are both 1. It is shifted out MSB first in mode 0: `sck_o` is low while idle, `mosi_o` does not change across a rising edge, and one serial period is 2·div system cycles. The byte taken with `byte_last_i` = 1 is the last image byte.
- R6: If `cdone_i` is 0 after the last image byte, the sequence ends with `err_o` = 2 (transfer failure), and no clocks follow the image.
- R7: If `cdone_i` is 1 after the last image byte, ceil(ACT_CLKS/8) zero bytes (7 bytes, 56 clocks, by default) follow with `cs_no` low. The sequence then ends with `done_ok_o` = 1 and `err_o` = 0. The two flags are never 1 together.
- R8: A divider value is accepted only from ceil(CLK_HZ/(2·F_MAX_HZ)) to floor(CLK_HZ/(2·F_MIN_HZ)), which is 1 to 25 at 50 MHz. Any other value makes the start end at once with `err_o` = 3 (unsupported), and `creset_no`, `cs_no` and `sck_o` do not move.
- R9: A start with `partial_i` = 1 is refused with `err_o` = 3, and `creset_no`, `cs_no` and `sck_o` do not move.
- R10: `operating_o` equals `cdone_i` at all times, whatever the sequencer is doing.
- R11: `busy_o` goes high in the cycle after an accepted start and stays high until the sequence ends. `byte_ready_o` is 1 only while busy, with `cs_no` low and `creset_no` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| partial_i | input | 1 | Start asks for partial reconfiguration (refused) |
| div_i | input | DIV_W | Serial clock half-period in system cycles |
| byte_i | input | 8 | Image byte |
| byte_valid_i | input | 1 | Image byte valid |
| byte_last_i | input | 1 | Image byte is the final one |
| byte_ready_o | output | 1 | Sequencer takes the byte this cycle |
| cdone_i | input | 1 | Target done flag |
| creset_no | output | 1 | Target reset, active low |
| cs_no | output | 1 | SPI chip select, active low |
| sck_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | SPI data to target |
| busy_o | output | 1 | Sequence running |
| done_ok_o | output | 1 | Last sequence succeeded |
| err_o | output | 2 | 0 none, 1 reset failure, 2 transfer failure, 3 unsupported |
| operating_o | output | 1 | Target reported operating (done flag high) |

## Verification
Two events can fall in the same cycle. The first is the shifter retiring one byte while the handshake takes the next. The bench provokes it by holding `byte_valid_i` high for the whole image, so each new byte is offered in the exact cycle the previous byte's final falling edge completes. It judges the result by rebuilding every byte from the serial lines and comparing it with the expected image. The second is the target's done flag rising on the final rising clock edge of the last image byte, just before the done check. The bench model raises `cdone_i` from inside that edge, and the run must end with activation and success at every divider value from 1 to 25.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_RESET = 2'd1,
    ERR_DONE  = 2'd2,
    ERR_UNSUP = 2'd3
  } err_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_CHK0, S_HK, S_GAP, S_XFER, S_CHK1, S_ACT
  } seq_e;
endpackage

// File: rtl/cfg_delay.sv
module cfg_delay #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_spi_shifter.sv
module cfg_spi_shifter #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [7:0]       data_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             busy_o,
  output logic             sck_o,
  output logic             mosi_o
);
  logic [7:0]       sr_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0; bit_q <= '0; cnt_q <= '0; sck_q <= 1'b0; act_q <= 1'b0;
    end else if (load_i) begin
      sr_q <= data_i; bit_q <= '0; cnt_q <= '0; sck_q <= 1'b0; act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == div_i - DIV_W'(1)) begin
        cnt_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;                 // target samples here
        end else begin
          sck_q <= 1'b0;                 // data moves on falling edge
          if (bit_q == 3'd7) act_q <= 1'b0;
          else begin
            bit_q <= bit_q + 3'd1;
            sr_q  <= {sr_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign busy_o = act_q;
  assign sck_o  = sck_q;
  assign mosi_o = act_q & sr_q[7];
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int RST_NS   = 1000,
  parameter int HK_US    = 1200,
  parameter int F_MIN_HZ = 1_000_000,
  parameter int F_MAX_HZ = 25_000_000,
  parameter int ACT_CLKS = 49,
  parameter int DIV_W    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             partial_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  input  logic             byte_last_i,
  output logic             byte_ready_o,
  input  logic             cdone_i,
  output logic             creset_no,
  output logic             cs_no,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             busy_o,
  output logic             done_ok_o,
  output logic [1:0]       err_o,
  output logic             operating_o
);
  localparam longint RST_CYC_L = (longint'(CLK_HZ) * longint'(RST_NS) + 64'd999_999_999) / 64'd1_000_000_000;
  localparam longint HK_CYC_L  = (longint'(CLK_HZ) * longint'(HK_US) + 64'd999_999) / 64'd1_000_000;
  localparam int RST_CYC   = int'(RST_CYC_L);
  localparam int HK_CYC    = int'(HK_CYC_L);
  localparam int DIV_MIN_R = (CLK_HZ + 2 * F_MAX_HZ - 1) / (2 * F_MAX_HZ);
  localparam int DIV_MIN   = (DIV_MIN_R < 1) ? 1 : DIV_MIN_R;
  localparam int DIV_MAX   = CLK_HZ / (2 * F_MIN_HZ);
  localparam int ACT_BYTES = (ACT_CLKS + 7) / 8;
  localparam int T_MAX     = (RST_CYC > HK_CYC) ? RST_CYC : HK_CYC;
  localparam int T_W       = $clog2(T_MAX + 1);
  localparam int A_W       = $clog2(ACT_BYTES + 1);

  seq_e             state_q;
  err_e             err_q;
  logic             ok_q, last_q;
  logic [DIV_W-1:0] div_q;
  logic [A_W-1:0]   act_q;

  logic           tmr_load, tmr_exp;
  logic [T_W-1:0] tmr_val;
  logic           sh_load, sh_busy;
  logic [7:0]     sh_data;
  logic           div_ok, start_ok;

  assign div_ok   = (div_i >= DIV_W'(DIV_MIN)) && (div_i <= DIV_W'(DIV_MAX));
  assign start_ok = start_i && !partial_i && div_ok;
  assign byte_ready_o = (state_q == S_XFER) && !sh_busy && !last_q;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_data  = 8'h00;
    unique case (state_q)
      S_IDLE: if (start_ok) begin tmr_load = 1'b1; tmr_val = T_W'(RST_CYC); end
      S_CHK0: if (!cdone_i) begin tmr_load = 1'b1; tmr_val = T_W'(HK_CYC); end
      S_XFER: if (byte_ready_o && byte_valid_i) begin sh_load = 1'b1; sh_data = byte_i; end
      S_ACT:  if (!sh_busy && act_q != '0) sh_load = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; err_q <= ERR_NONE; ok_q <= 1'b0;
      last_q <= 1'b0; div_q <= '0; act_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          ok_q <= 1'b0;
          if (!start_ok) err_q <= ERR_UNSUP;
          else begin
            err_q <= ERR_NONE; div_q <= div_i; last_q <= 1'b0; state_q <= S_RST;
          end
        end
        S_RST:  if (tmr_exp) state_q <= S_CHK0;
        S_CHK0: if (cdone_i) begin err_q <= ERR_RESET; state_q <= S_IDLE; end
                else state_q <= S_HK;
        S_HK:   if (tmr_exp) state_q <= S_GAP;
        S_GAP:  state_q <= S_XFER;
        S_XFER: begin
          if (sh_load && byte_last_i) last_q <= 1'b1;
          if (last_q && !sh_busy) state_q <= S_CHK1;
        end
        S_CHK1: if (cdone_i) begin act_q <= A_W'(ACT_BYTES); state_q <= S_ACT; end
                else begin err_q <= ERR_DONE; state_q <= S_IDLE; end
        S_ACT: begin
          if (sh_load) act_q <= act_q - A_W'(1);
          if (!sh_busy && act_q == '0) begin ok_q <= 1'b1; state_q <= S_IDLE; end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  cfg_delay #(.W(T_W)) u_delay (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  cfg_spi_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sh_load),
    .data_i (sh_data),
    .div_i  (div_q),
    .busy_o (sh_busy),
    .sck_o  (sck_o),
    .mosi_o (mosi_o)
  );

  assign creset_no   = (state_q != S_RST);
  assign cs_no       = (state_q == S_IDLE) || (state_q == S_GAP);
  assign busy_o      = (state_q != S_IDLE);
  assign done_ok_o   = ok_q;
  assign err_o       = err_q;
  assign operating_o = cdone_i;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             partial_i,
  input logic [DIV_W-1:0] div_i,
  input logic             byte_ready_o,
  input logic             creset_no,
  input logic             cs_no,
  input logic             sck_o,
  input logic             mosi_o,
  input logic             busy_o,
  input logic             done_ok_o,
  input logic [1:0]       err_o
);
  // R2
  rst_with_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !creset_no |-> !cs_no);

  // R5
  sck_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);

  // R5
  mosi_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> $stable(mosi_o));

  // R7
  ok_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_ok_o |-> (err_o == 2'd0));

  // R9
  partial_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && partial_i) |=> (cs_no && creset_no && !busy_o && !sck_o));

  // R11
  ready_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> (busy_o && !cs_no && creset_no));

  // R8
  div_zero_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && div_i == '0) |=> (!busy_o && cs_no && creset_no));
endmodule

bind cfg_loader cfg_loader_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;
  localparam int DIV_W   = 6;
  localparam int HK_US   = 2;
  localparam int RST_EXP = 50;    // 50 MHz * 1000 ns
  localparam int HK_EXP  = 100;   // 50 MHz * 2 us
  localparam int DMIN    = 1;
  localparam int DMAX    = 25;
  localparam int ACT     = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             start = 1'b0, partial = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic [7:0]       bdata = '0;
  logic             bvalid = 1'b0, blast = 1'b0;
  logic             bready, cdone = 1'b0;
  logic             creset_n, cs_n, sck, mosi, busy, done_ok, operating;
  logic [1:0]       err;

  cfg_loader #(.HK_US(HK_US), .DIV_W(DIV_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .partial_i(partial), .div_i(div),
    .byte_i(bdata), .byte_valid_i(bvalid), .byte_last_i(blast), .byte_ready_o(bready),
    .cdone_i(cdone), .creset_no(creset_n), .cs_no(cs_n), .sck_o(sck), .mosi_o(mosi),
    .busy_o(busy), .done_ok_o(done_ok), .err_o(err), .operating_o(operating)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc++;

  int mode = 0, n_img = 0;
  logic [7:0] img [16];
  logic [7:0] rx [32];
  int rx_n = 0, sbits = 0, rise_n = 0, rise_c0 = 0, rise_c1 = 0;
  logic [7:0] sbuf = '0;

  // target model: sample on rising edge, raise done after the last image byte
  always @(posedge sck) begin
    if (!cs_n) begin
      sbuf = {sbuf[6:0], mosi};
      sbits++;
      if (rise_n == 0) rise_c0 = cyc;
      if (rise_n == 1) rise_c1 = cyc;
      rise_n++;
      if (sbits == 8) begin
        if (rx_n < 32) rx[rx_n] = sbuf;
        rx_n++;
        sbits = 0;
        if (mode == 0 && rx_n == n_img) cdone = 1'b1;
      end
    end
  end

  always @(negedge creset_n) if (mode != 1) cdone = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int dv, input int n, input int md, input int seed);
    int idx, rst_len, hk_len, op_bad, bad;
    bit pend, gap, gap_ok;
    mode = md; n_img = n; rx_n = 0; sbits = 0; rise_n = 0;
    for (int k = 0; k < 16; k++) img[k] = 8'((seed + k * 73 + 11) & 255);
    cdone = (md == 1);
    idx = 0; pend = 0; gap = 0; gap_ok = 0; rst_len = 0; hk_len = 0; op_bad = 0;
    bvalid = (n > 0); bdata = img[0]; blast = (n == 1);
    @(negedge clk); start = 1'b1; partial = 1'b0; div = DIV_W'(dv);
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R11", "busy after start", int'(busy), 1);
    while (busy) begin
      if (!creset_n) rst_len++;
      else if (rst_len > 0 && !gap) begin
        if (!cs_n) hk_len++;
        else begin gap = 1; gap_ok = (rise_n == 0); end
      end
      if (operating !== cdone) op_bad++;
      if (pend) begin
        idx++;
        bvalid = (idx < n);
        bdata  = img[idx & 15];
        blast  = (idx == n - 1);
      end
      pend = bvalid && bready;
      @(negedge clk);
    end
    bvalid = 1'b0; blast = 1'b0;
    chk(rst_len >= RST_EXP, "R2", "reset low cycles", rst_len, RST_EXP);
    chk(op_bad == 0, "R10", "operating mismatches", op_bad, 0);
    chk(cs_n === 1'b1 && creset_n === 1'b1, "R11", "pins idle at end", int'({cs_n, creset_n}), 3);
    if (md == 1) begin
      chk(err == 2'd1, "R3", "err after reset fail", int'(err), 1);
      chk(rise_n == 0, "R3", "sck pulses", rise_n, 0);
    end else if (md == 2) begin
      chk(err == 2'd2, "R6", "err after done fail", int'(err), 2);
      chk(rx_n == n, "R6", "bytes clocked", rx_n, n);
      chk(done_ok == 1'b0, "R6", "done_ok", int'(done_ok), 0);
    end else begin
      chk(hk_len >= HK_EXP, "R4", "housekeeping cs low", hk_len, HK_EXP);
      chk(gap && gap_ok, "R4", "cs gap before image", int'(gap_ok), 1);
      chk(rise_c1 - rise_c0 == 2 * dv, "R5", "sck period", rise_c1 - rise_c0, 2 * dv);
      bad = 0;
      for (int k = 0; k < n; k++) if (rx[k] !== img[k]) bad++;
      chk(bad == 0, "R5", "image byte mismatches", bad, 0);
      chk(rx_n == n + ACT, "R7", "bytes clocked", rx_n, n + ACT);
      bad = 0;
      for (int k = n; k < n + ACT && k < 32; k++) if (rx[k] !== 8'h00) bad++;
      chk(bad == 0, "R7", "nonzero activation bytes", bad, 0);
      chk(done_ok == 1'b1 && err == 2'd0, "R7", "done_ok/err", int'({done_ok, err}), 4);
    end
  endtask

  task automatic reject(input int dv, input bit part, input string req);
    int bad;
    bad = 0;
    @(negedge clk); start = 1'b1; partial = part; div = DIV_W'(dv);
    @(negedge clk); start = 1'b0; partial = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (!cs_n || !creset_n || sck || busy) bad++;
      @(negedge clk);
    end
    chk(bad == 0, req, "pin activity on refused start", bad, 0);
    chk(err == 2'd3, req, "err on refused start", int'(err), 3);
  endtask

  initial begin
    #(20 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(creset_n === 1'b1 && cs_n === 1'b1 && sck === 1'b0, "R1", "pins in reset",
        int'({creset_n, cs_n, sck}), 6);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done_ok === 1'b0 && err === 2'd0, "R1", "status after reset",
        int'({busy, done_ok, err}), 0);

    cdone = 1'b0; @(negedge clk);
    chk(operating === 1'b0, "R10", "operating low", int'(operating), 0);
    cdone = 1'b1; @(negedge clk);
    chk(operating === 1'b1, "R10", "operating high", int'(operating), 1);

    // divider sweep: every code of the port
    for (int d = 0; d < (1 << DIV_W); d++) begin
      if (d >= DMIN && d <= DMAX) run(d, 3, 0, d * 29);
      else reject(d, 1'b0, "R8");
    end

    reject(5, 1'b1, "R9");
    reject(0, 1'b1, "R9");
    run(1, 12, 0, 200);
    run(2, 1, 0, 244);
    run(4, 2, 1, 7);
    run(3, 4, 2, 90);
    run(DMAX, 2, 0, 17);
    run(DMIN, 16, 0, 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule